// File: doc/BRIEF.md
# Transactional Execution State Controller

This block follows the hardware transaction state of one processor thread. It moves between three modes: idle (no transaction), active (inside a transaction) and suspended (a transaction is open but paused, for example while an interrupt handler runs). The decode stage sends it one command per cycle: begin, end, abort, suspend or resume. The interrupt logic reports interrupt entry and return. A cache-side tracker reports footprint conflicts, and the translation logic reports invalidations that hit the footprint.

Its outputs are strobes for the surrounding core. A checkpoint-capture strobe marks the start of the outermost transaction. A commit pulse marks its successful end. A failure raises a rollback strobe and a redirect request in the same cycle, and the redirect address is the handler given at the outermost begin. The block also shows the last failure cause, the current mode, the nesting depth and the flavour of the open transaction.

Nested begins add no new checkpoint: every failure rolls back to the outermost one. A transaction can be begun as rollback-only. In that flavour the block still captures and restores state, but it ignores footprint conflicts and invalidations. While suspended, a failure is only noted. The rollback and the redirect wait until the thread resumes.

Top module: `txn_state_ctl`

## Requirements
- R1: After reset, mode is 0 (idle), depth is 0, the failure cause is 0, the redirect address is 0 and every strobe is low.
- R2: Command code 1 (begin) in idle mode raises ckpt_capture for one cycle. The mode becomes 1 (active) and depth becomes 1. The handler and the rollback-only flag given with the command are stored, and the cause clears to 0.
- R3: In active mode, begin raises depth by one without a capture strobe. Command code 2 (end) lowers depth by one. An end at depth 1 instead raises commit for one cycle and returns to idle with depth 0.
- R4: A begin at the maximum depth (7) fails the transaction with cause 3 (nesting error).
- R5: Each failure raises rollback and redirect together for exactly one cycle. In that cycle mode and depth are 0 and redirect_addr holds the outermost handler. Command code 3 (abort) in active mode fails with cause 1.
- R6: In a normal transaction in active mode, a tracker conflict or a translation-invalidation hit fails it with cause 2 (general).
- R7: A rollback-only transaction ignores tracker conflicts and invalidation hits, but abort still fails it and end still commits it.
- R8: In active mode, command code 4 (suspend) or an interrupt entry moves to mode 2 (suspended) and keeps the depth. Command code 5 (resume) or an interrupt return moves back to mode 1.
- R9: While suspended, a failure raises no strobe and leaves the mode at 2. Only the first failure cause is kept. On resume or interrupt return the deferred failure fires with that cause.
- R10: While suspended, an end or a begin records cause 4 (illegal while suspended), and a suspend records cause 3. All of these are deferred like other suspended failures.
- R11: In idle mode every command other than begin, and every interrupt, conflict or invalidation input, has no effect on the outputs.
- R12: In active mode a failure takes priority over an interrupt entry and over any command in the same cycle, and an interrupt entry takes priority over the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Command: 0 none, 1 begin, 2 end, 3 abort, 4 suspend, 5 resume |
| cmd_rb_only | input | 1 | With begin: open a rollback-only transaction |
| cmd_handler | input | AW | With begin: failure handler address |
| irq_take | input | 1 | Interrupt entry |
| irq_return | input | 1 | Return from interrupt |
| trk_conflict | input | 1 | Footprint conflict from the cache tracker |
| xlat_inval_hit | input | 1 | Translation invalidation hit the footprint |
| ckpt_capture | output | 1 | Capture checkpoint (one cycle) |
| rollback | output | 1 | Restore checkpoint (one cycle) |
| redirect | output | 1 | Redirect fetch to handler (one cycle) |
| commit | output | 1 | Outermost transaction committed (one cycle) |
| redirect_addr | output | AW | Handler of the outermost begin |
| fail_cause | output | 3 | Last failure cause: 0 none, 1 abort, 2 general, 3 nesting, 4 illegal while suspended |
| mode | output | 2 | 0 idle, 1 active, 2 suspended |
| depth | output | DW | Nesting depth |
| rb_only | output | 1 | Open transaction is rollback-only |

## Verification
The hardest case to reach is a deferred failure: a failure recorded while suspended, then a second and different failure, then the resume that releases the first one. To get there the bench builds a nested transaction and suspends it, by command or by interrupt entry. It then injects each kind of suspended failure and adds a conflict as the second failure. Finally it leaves suspension by both exit paths, checking that no strobe appears before the exit and that the first cause appears on it.

// File: rtl/txn_state_ctl.sv
module txn_state_ctl #(
  parameter int AW = 16,
  parameter int DW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cmd_op,
  input  logic          cmd_rb_only,
  input  logic [AW-1:0] cmd_handler,
  input  logic          irq_take,
  input  logic          irq_return,
  input  logic          trk_conflict,
  input  logic          xlat_inval_hit,
  output logic          ckpt_capture,
  output logic          rollback,
  output logic          redirect,
  output logic          commit,
  output logic [AW-1:0] redirect_addr,
  output logic [2:0]    fail_cause,
  output logic [1:0]    mode,
  output logic [DW-1:0] depth,
  output logic          rb_only
);

  localparam logic [1:0] M_IDLE = 2'd0, M_ACT = 2'd1, M_SUSP = 2'd2;
  localparam logic [2:0] C_NONE = 3'd0, C_ABORT = 3'd1, C_GEN = 3'd2,
                         C_NEST = 3'd3, C_ILL = 3'd4;
  localparam logic [DW-1:0] DMAX = '1;
  localparam logic [DW-1:0] DONE = DW'(1);

  logic       pend_v;
  logic [2:0] pend_c;

  wire is_beg = cmd_op == 3'd1;
  wire is_end = cmd_op == 3'd2;
  wire is_abt = cmd_op == 3'd3;
  wire is_sus = cmd_op == 3'd4;
  wire is_res = cmd_op == 3'd5;
  wire trk_hit = !rb_only && (trk_conflict || xlat_inval_hit);

  logic [2:0] act_c, sus_c, fire_c;

  always_comb begin
    if (is_abt)                    act_c = C_ABORT;
    else if (trk_hit)              act_c = C_GEN;
    else if (is_beg && depth == DMAX) act_c = C_NEST;
    else                           act_c = C_NONE;

    if (is_abt)                    sus_c = C_ABORT;
    else if (trk_hit)              sus_c = C_GEN;
    else if (is_end || is_beg)     sus_c = C_ILL;
    else if (is_sus)               sus_c = C_NEST;
    else                           sus_c = C_NONE;

    fire_c = pend_v ? pend_c : sus_c;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_IDLE;
      depth <= '0;
      rb_only <= 1'b0;
      redirect_addr <= '0;
      fail_cause <= C_NONE;
      pend_v <= 1'b0;
      pend_c <= C_NONE;
      ckpt_capture <= 1'b0;
      rollback <= 1'b0;
      redirect <= 1'b0;
      commit <= 1'b0;
    end else begin
      ckpt_capture <= 1'b0;
      rollback <= 1'b0;
      redirect <= 1'b0;
      commit <= 1'b0;
      case (mode)
        M_IDLE: if (is_beg) begin
          mode <= M_ACT;
          depth <= DONE;
          ckpt_capture <= 1'b1;
          redirect_addr <= cmd_handler;
          rb_only <= cmd_rb_only;
          fail_cause <= C_NONE;
          pend_v <= 1'b0;
        end
        M_ACT: begin
          if (act_c != C_NONE) begin
            rollback <= 1'b1;
            redirect <= 1'b1;
            mode <= M_IDLE;
            depth <= '0;
            rb_only <= 1'b0;
            fail_cause <= act_c;
          end else if (irq_take || is_sus) begin
            mode <= M_SUSP;
          end else if (is_beg) begin
            depth <= depth + DONE;
          end else if (is_end) begin
            if (depth == DONE) begin
              commit <= 1'b1;
              mode <= M_IDLE;
              depth <= '0;
              rb_only <= 1'b0;
            end else begin
              depth <= depth - DONE;
            end
          end
        end
        M_SUSP: begin
          if (is_res || irq_return) begin
            if (fire_c != C_NONE) begin
              rollback <= 1'b1;
              redirect <= 1'b1;
              mode <= M_IDLE;
              depth <= '0;
              rb_only <= 1'b0;
              fail_cause <= fire_c;
              pend_v <= 1'b0;
            end else begin
              mode <= M_ACT;
            end
          end else if (sus_c != C_NONE && !pend_v) begin
            pend_v <= 1'b1;
            pend_c <= sus_c;
          end
        end
        default: begin
          mode <= M_IDLE;
          depth <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/txn_state_ctl_chk.sv
module txn_state_ctl_chk #(
  parameter int AW = 16,
  parameter int DW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    cmd_op,
  input logic          irq_return,
  input logic          irq_take,
  input logic          trk_conflict,
  input logic          xlat_inval_hit,
  input logic          ckpt_capture,
  input logic          rollback,
  input logic          redirect,
  input logic          commit,
  input logic [1:0]    mode,
  input logic [DW-1:0] depth,
  input logic          rb_only
);

  // R5
  pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rollback == redirect);

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rollback |=> !rollback);

  // R5
  fail_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rollback |-> (mode == 2'd0 && depth == '0));

  // R3
  commit_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(depth) == DW'(1) && mode == 2'd0));

  // R2
  capture_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_capture |-> ($past(mode) == 2'd0 && depth == DW'(1)));

  // R9
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd2 && $past(cmd_op) != 3'd5 && !$past(irq_return)) |-> !rollback);

  // R8
  open_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0) |-> (depth != '0));

  // R7
  rb_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_only && mode == 2'd1 && cmd_op == 3'd0 && (trk_conflict || xlat_inval_hit)) |=> !rollback);

endmodule

bind txn_state_ctl txn_state_ctl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .irq_return(irq_return),
  .irq_take(irq_take), .trk_conflict(trk_conflict), .xlat_inval_hit(xlat_inval_hit),
  .ckpt_capture(ckpt_capture), .rollback(rollback), .redirect(redirect),
  .commit(commit), .mode(mode), .depth(depth), .rb_only(rb_only)
);

// File: tb/txn_state_ctl_tb.sv
`timescale 1ns/1ps
module txn_state_ctl_tb;
  localparam int AW = 16;
  localparam int DW = 3;

  logic clk = 0, rst_n = 0;
  logic [2:0] cmd_op = 0;
  logic cmd_rb_only = 0;
  logic [AW-1:0] cmd_handler = 0;
  logic irq_take = 0, irq_return = 0, trk_conflict = 0, xlat_inval_hit = 0;
  logic ckpt_capture, rollback, redirect, commit, rb_only;
  logic [AW-1:0] redirect_addr;
  logic [2:0] fail_cause;
  logic [1:0] mode;
  logic [DW-1:0] depth;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  txn_state_ctl #(.AW(AW), .DW(DW)) u_dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic it = 0, input logic ir = 0,
                      input logic cf = 0, input logic iv = 0, input logic rbo = 0,
                      input logic [AW-1:0] h = 0);
    @(negedge clk);
    cmd_op = op; irq_take = it; irq_return = ir; trk_conflict = cf;
    xlat_inval_hit = iv; cmd_rb_only = rbo; cmd_handler = h;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_fail(string req, int cause, int addr);
    chk({req, " rollback"}, rollback, 1);
    chk({req, " redirect"}, redirect, 1);
    chk({req, " cause"}, fail_cause, cause);
    chk({req, " mode"}, mode, 0);
    chk({req, " depth"}, depth, 0);
    chk({req, " addr"}, redirect_addr, addr);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk("R1 mode", mode, 0); chk("R1 depth", depth, 0); chk("R1 cause", fail_cause, 0);
    chk("R1 addr", redirect_addr, 0);
    chk("R1 strobes", {ckpt_capture, rollback, redirect, commit}, 0);
    @(negedge clk); rst_n = 1;

    // R11: idle ignores everything but begin
    for (int op = 0; op < 6; op++) begin
      if (op == 1) continue;
      step(3'(op), 1, 1, 1, 1);
      chk("R11 mode", mode, 0); chk("R11 depth", depth, 0);
      chk("R11 strobes", {ckpt_capture, rollback, redirect, commit}, 0);
    end

    // R2/R3: nesting sweep
    for (int n = 1; n <= 7; n++) begin
      step(1, 0, 0, 0, 0, 0, 16'h1000 + 16'(n));
      chk("R2 capture", ckpt_capture, 1); chk("R2 mode", mode, 1);
      chk("R2 depth", depth, 1); chk("R2 addr", redirect_addr, 16'h1000 + n);
      for (int k = 2; k <= n; k++) begin
        step(1, 0, 0, 0, 0, 1, 16'h2222);
        chk("R3 nested depth", depth, k); chk("R3 no capture", ckpt_capture, 0);
        chk("R3 rb flag kept", rb_only, 0);
      end
      for (int k = n; k >= 1; k--) begin
        step(2);
        chk("R3 end depth", depth, k - 1);
        chk("R3 commit", commit, (k == 1) ? 1 : 0);
        chk("R3 mode", mode, (k == 1) ? 0 : 1);
      end
      step(0);
      chk("R3 commit single", commit, 0);
    end

    // R4: overflow
    step(1, 0, 0, 0, 0, 0, 16'h3300);
    for (int k = 2; k <= 7; k++) step(1);
    chk("R4 depth max", depth, 7);
    step(1);
    expect_fail("R4", 3, 16'h3300);

    // R5: abort at each depth, nested handler ignored
    for (int n = 1; n <= 7; n++) begin
      step(1, 0, 0, 0, 0, 0, 16'h4400 + 16'(n));
      for (int k = 2; k <= n; k++) step(1, 0, 0, 0, 0, 0, 16'hbeef);
      step(3);
      expect_fail("R5", 1, 16'h4400 + n);
      step(0);
      chk("R5 one cycle", rollback, 0); chk("R5 redirect one cycle", redirect, 0);
    end

    // R6/R7: conflict sources x flavour
    for (int rb = 0; rb < 2; rb++) begin
      for (int src = 0; src < 2; src++) begin
        step(1, 0, 0, 0, 0, 1'(rb), 16'h5500);
        step(0, 0, 0, src == 0, src == 1);
        if (rb == 0) expect_fail("R6", 2, 16'h5500);
        else begin
          chk("R7 ignored rollback", rollback, 0); chk("R7 mode", mode, 1);
          chk("R7 rb flag", rb_only, 1);
          step(2);
          chk("R7 commit", commit, 1);
        end
      end
    end
    step(1, 0, 0, 0, 0, 1, 16'h5600);
    step(3);
    expect_fail("R7 abort", 1, 16'h5600);

    // R8: suspend entry/exit paths
    for (int en = 0; en < 2; en++)
      for (int ex = 0; ex < 2; ex++) begin
        step(1, 0, 0, 0, 0, 0, 16'h6600);
        step(1);
        if (en == 0) step(4); else step(0, 1);
        chk("R8 suspended", mode, 2); chk("R8 depth kept", depth, 2);
        if (ex == 0) step(5); else step(0, 0, 1);
        chk("R8 resumed", mode, 1); chk("R8 no rollback", rollback, 0);
        step(2); step(2);
        chk("R8 commit", commit, 1);
      end

    // R9/R10: deferred failures
    for (int kind = 0; kind < 6; kind++)
      for (int en = 0; en < 2; en++)
        for (int ex = 0; ex < 2; ex++) begin
          int exp_c;
          exp_c = (kind == 0 || kind == 1) ? 2 : (kind == 2) ? 1 :
                  (kind == 3 || kind == 5) ? 4 : 3;
          step(1, 0, 0, 0, 0, 0, 16'h7700 + 16'(kind));
          step(1);
          if (en == 0) step(4); else step(0, 1);
          case (kind)
            0: step(0, 0, 0, 1, 0);
            1: step(0, 0, 0, 0, 1);
            2: step(3);
            3: step(2);
            4: step(4);
            default: step(1);
          endcase
          chk("R9 held mode", mode, 2); chk("R9 no rollback", rollback, 0);
          chk("R10 depth kept", depth, 2);
          step(0); step(0, 0, 0, 1, 0);
          chk("R9 still held", rollback, 0);
          if (ex == 0) step(5); else step(0, 0, 1);
          expect_fail((kind >= 3) ? "R10 deferred" : "R9 deferred", exp_c, 16'h7700 + kind);
        end

    // R7 in suspension: rollback-only conflict ignored
    step(1, 0, 0, 0, 0, 1, 16'h8800);
    step(4);
    step(0, 0, 0, 1, 1);
    step(5);
    chk("R7 susp ignore", rollback, 0); chk("R7 susp mode", mode, 1);
    step(2);

    // R12: priorities
    step(1, 0, 0, 0, 0, 0, 16'h9900);
    step(2, 0, 0, 1, 0);
    chk("R12 fail over end", commit, 0);
    expect_fail("R12", 2, 16'h9900);
    step(1, 0, 0, 0, 0, 0, 16'h9901);
    step(2, 1);
    chk("R12 irq over end mode", mode, 2); chk("R12 irq over end depth", depth, 1);
    chk("R12 no commit", commit, 0);
    step(3, 0, 1);
    expect_fail("R12 abort on exit", 1, 16'h9901);
    step(1, 0, 0, 0, 0, 0, 16'h9902);
    step(0, 1, 0, 1, 0);
    expect_fail("R12 fail over irq", 2, 16'h9902);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule